// File: doc/BRIEF.md
# Serial-Loaded Eight-Way Switch Enable Register

This block holds the on/off state of a bank of switch channels and is written over a three-line serial port: an active-low frame select, a serial clock and a serial data line. While the frame select is low, each falling serial-clock edge moves one data bit into a shift register. When the frame select returns high, the whole shift register is copied to the parallel switch-enable outputs in one step, so all channels change together.

A serial data output presents the bit that leaves the top of the shift register. It is updated on rising serial-clock edges, which lets units be cascaded. All units in a cascade share frame select and serial clock. One long frame then fills every unit, and all of them update at the same moment when the frame closes.

The block runs on a system clock. It brings the three serial lines in through synchronisers and finds serial-clock edges by comparing successive synchronised samples. The system clock must run at least four times faster than the serial clock.

Top module: `serial_switch_ctrl`

## Requirements
- R1: While frame_ni is high, toggling sclk_i or sdi_i changes neither the shift register nor sdo_o.
- R2: During a frame (frame_ni low), one bit of sdi_i is taken into the shift register on each falling edge of sclk_i.
- R3: Bits enter at bit 0 and move toward bit NUM_CH-1, so the first of eight bits ends in sw_en_o[7]. sw_en_o[k] drives channel k+1, and a 1 turns that channel on.
- R4: A frame may carry any number of clocks, zero or more than eight included. After a frame, the register holds the last eight bits received, and older bits are pushed out at the top.
- R5: sw_en_o changes only when frame_ni rises. At that point all bits load together from the shift register.
- R6: On each rising sclk_i edge inside a frame, sdo_o takes the current top bit of the shift register. sdo_o keeps its value across falling edges and while frame_ni is high.
- R7: After power-up, and whenever rst_ni is low, the shift register, sw_en_o and sdo_o are all zero.
- R8: A frame with no sclk_i falling edge still loads sw_en_o from the unchanged shift register when it closes.
- R9: Two units in a chain (sdo_o feeding the next unit's sdi_i, with frame and clock shared) given one 16-bit frame end with the last eight bits in the first unit and the first eight bits in the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| frame_ni | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out toward the next unit |
| sw_en_o | output | NUM_CH | Switch enables, 1 = on |

## Verification
The bench builds the block with NUM_CH = 8 and SYNC_STAGES = 2. This makes it cheap to send all 256 enable codes as eight-bit frames. With a second unit cascaded behind the first, each of those frames also checks that the downstream unit received the previous code through the chain. Frame lengths from zero to twelve clocks cover the short, empty and overlong cases. Idle-line noise, a 16-bit cascade frame and a reset between frames cover the hold, chain and clear behaviour.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef struct packed {
    logic sclk;
    logic frame_n;
    logic sdi;
  } ser_lines_t;

  localparam ser_lines_t LINES_IDLE = '{sclk: 1'b0, frame_n: 1'b1, sdi: 1'b0};

  typedef struct packed {
    logic active;
    logic sclk_rise;
    logic sclk_fall;
    logic frame_close;
  } ser_evt_t;
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ssc_evt.sv
module ssc_evt
  import ssc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ser_lines_t lines_i,
  output ser_evt_t   evt_o
);
  logic sclk_q, frame_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      frame_n_q <= 1'b1;
    end else begin
      sclk_q    <= lines_i.sclk;
      frame_n_q <= lines_i.frame_n;
    end
  end

  always_comb begin
    evt_o.active      = ~lines_i.frame_n;
    evt_o.sclk_rise   = ~sclk_q & lines_i.sclk;
    evt_o.sclk_fall   = sclk_q & ~lines_i.sclk;
    evt_o.frame_close = ~frame_n_q & lines_i.frame_n;
  end
endmodule

// File: rtl/ssc_shreg.sv
module ssc_shreg
  import ssc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ser_evt_t     evt_i,
  input  logic         sdi_i,
  output logic [W-1:0] shreg_o,
  output logic         sdo_o
);
  logic [W-1:0] shreg_q;
  logic         sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      sdo_q   <= 1'b0;
    end else begin
      if (evt_i.active && evt_i.sclk_fall) shreg_q <= {shreg_q[W-2:0], sdi_i};
      // top bit is driven out half a serial period ahead of the next sample
      if (evt_i.active && evt_i.sclk_rise) sdo_q <= shreg_q[W-1];
    end
  end

  assign shreg_o = shreg_q;
  assign sdo_o   = sdo_q;

  AST_IDLE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i.active |=> $stable(shreg_q)); // R1
  AST_FALL_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.active && evt_i.sclk_fall) |=>
      (shreg_q[W-1:1] == $past(shreg_q[W-2:0])) && (shreg_q[0] == $past(sdi_i))); // R2
  AST_SDO_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.active && evt_i.sclk_rise) |=> sdo_q == $past(shreg_q[W-1])); // R6
  AST_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_i.active && evt_i.sclk_rise) |=> $stable(sdo_q)); // R6
endmodule

// File: rtl/serial_switch_ctrl.sv
module serial_switch_ctrl
  import ssc_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              frame_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [NUM_CH-1:0] sw_en_o
);
  localparam int LW = $bits(ser_lines_t);

  ser_lines_t        raw_lines, s_lines;
  ser_evt_t          evt;
  logic [NUM_CH-1:0] shreg;
  logic [NUM_CH-1:0] sw_q;

  assign raw_lines = '{sclk: sclk_i, frame_n: frame_ni, sdi: sdi_i};

  ssc_sync #(
    .WIDTH  (LW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINES_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_lines),
    .q_o   (s_lines)
  );

  ssc_evt u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lines_i(s_lines),
    .evt_o  (evt)
  );

  ssc_shreg #(.W(NUM_CH)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .sdi_i  (s_lines.sdi),
    .shreg_o(shreg),
    .sdo_o  (sdo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_q <= '0;
    else if (evt.frame_close) sw_q <= shreg;
  end

  assign sw_en_o = sw_q;

  AST_LOAD_AT_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt.frame_close |=> sw_q == $past(shreg)); // R5
  AST_HOLD_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt.frame_close |=> $stable(sw_q)); // R5
  AST_CLOSE_IDLE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt.frame_close |-> !evt.active); // R5
endmodule

// File: tb/serial_switch_ctrl_tb_top.sv
module serial_switch_ctrl_tb_top;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, frame_n = 1'b1, sdi = 1'b0;
  logic sdo, dn_sdo;
  logic [7:0] sw, dn_sw;

  logic [7:0] up_mdl = '0, dn_mdl = '0, sw_exp = '0, dn_exp = '0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  serial_switch_ctrl #(.NUM_CH(8), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .frame_ni(frame_n),
    .sdi_i(sdi), .sdo_o(sdo), .sw_en_o(sw)
  );

  serial_switch_ctrl #(.NUM_CH(8), .SYNC_STAGES(2)) dn_i (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .frame_ni(frame_n),
    .sdi_i(sdo), .sdo_o(dn_sdo), .sw_en_o(dn_sw)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input int nbits, input logic [31:0] bits);
    logic out;
    frame_n = 1'b0;
    tick(HP);
    for (int i = nbits - 1; i >= 0; i--) begin
      sclk = 1'b1;
      sdi  = bits[i];
      tick(HP);
      out = up_mdl[7];
      chk(sdo == out, "R6 sdo after rise", {31'd0, sdo}, {31'd0, out});
      sclk = 1'b0;
      tick(HP);
      up_mdl = {up_mdl[6:0], bits[i]};
      dn_mdl = {dn_mdl[6:0], out};
      chk(sdo == out, "R6 sdo held across fall", {31'd0, sdo}, {31'd0, out});
    end
    chk(sw == sw_exp, "R5 no change while frame open", {24'd0, sw}, {24'd0, sw_exp});
    frame_n = 1'b1;
    tick(10);
    sw_exp = up_mdl;
    dn_exp = dn_mdl;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] sw_keep;
    logic       sdo_keep;
    tick(4);
    chk(sw == 8'h00, "R7 reset outputs", {24'd0, sw}, 32'd0);
    chk(sdo == 1'b0, "R7 reset sdo", {31'd0, sdo}, 32'd0);
    rst_ni = 1'b1;
    tick(4);

    // R3: every code, MSB first; also R9 chain carries previous code
    for (int v = 0; v < 256; v++) begin
      run_frame(8, v);
      chk(sw == v[7:0], "R3 code load", {24'd0, sw}, v);
      chk(dn_sw == dn_exp, "R9 chain previous code", {24'd0, dn_sw}, {24'd0, dn_exp});
    end

    // R4 / R8: frame lengths 0..12
    for (int len = 0; len <= 12; len++) begin
      logic [31:0] pat;
      pat = 32'h0000_B5C6 ^ (len * 32'h0000_0391);
      run_frame(len, pat);
      chk(sw == sw_exp, "R4 length sweep", {24'd0, sw}, {24'd0, sw_exp});
      if (len >= 8)
        chk(sw == pat[7:0], "R4 last eight kept", {24'd0, sw}, {24'd0, pat[7:0]});
    end

    // R1: noise while idle
    run_frame(8, 32'h96);
    sw_keep  = sw;
    sdo_keep = sdo;
    for (int k = 0; k < 20; k++) begin
      sclk = ~sclk;
      sdi  = k[1];
      tick(HP);
    end
    sclk = 1'b0;
    tick(HP);
    chk(sw == sw_keep, "R1 idle noise outputs", {24'd0, sw}, {24'd0, sw_keep});
    chk(sdo == sdo_keep, "R1 idle noise sdo", {31'd0, sdo}, {31'd0, sdo_keep});
    run_frame(0, 32'h0);
    chk(sw == 8'h96, "R1 R8 register untouched by idle noise", {24'd0, sw}, 32'h96);

    // R9: one 16-bit frame through two units
    run_frame(16, 32'h3C5A);
    chk(sw == 8'h5A, "R9 first unit last byte", {24'd0, sw}, 32'h5A);
    chk(dn_sw == 8'h3C, "R9 second unit first byte", {24'd0, dn_sw}, 32'h3C);

    // R7: reset between frames
    tick(2);
    rst_ni = 1'b0;
    tick(3);
    chk(sw == 8'h00, "R7 reset clears outputs", {24'd0, sw}, 32'd0);
    chk(dn_sw == 8'h00, "R7 reset clears chain unit", {24'd0, dn_sw}, 32'd0);
    chk(sdo == 1'b0, "R7 reset clears sdo", {31'd0, sdo}, 32'd0);
    rst_ni = 1'b1;
    up_mdl = '0; dn_mdl = '0; sw_exp = '0; dn_exp = '0;
    tick(4);
    run_frame(0, 32'h0);
    chk(sw == 8'h00, "R7 R8 shift register cleared", {24'd0, sw}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule